// File: doc/BRIEF.md
# Display Command Packet Formatter

This block turns a handful of host register writes into one command packet for a serial display link and streams that packet out one byte at a time. The host programs a type register, a word count and up to four 16-bit payload words over a simple write port. It then writes a trigger. The formatter builds the four header bytes, including an error-correcting byte, and for long packets appends the payload and a 16-bit checksum. The bytes leave through a valid/ready byte interface.

A `busy` output covers the whole packet. While it is high, the registers are locked and further triggers are ignored. A trigger that cannot be honoured is refused with a one-cycle `reject` pulse and produces no output. A trigger is refused when the block is disabled, when the packet kind is unknown, or when a long packet asks for more than eight payload bytes.

The controller has four states. IDLE waits for a trigger. HDR sends header bytes 0 to 3. PAY sends the payload bytes. CSUM sends the two checksum bytes. The transitions are:

- IDLE to HDR: an accepted trigger.
- HDR to IDLE: after the fourth byte of a short packet.
- HDR to PAY: after the fourth byte of a long packet with a non-zero count.
- HDR to CSUM: after the fourth byte of a long packet with a zero count.
- PAY to CSUM: after the last payload byte.
- CSUM to IDLE: after the second checksum byte.

Every transition out of HDR, PAY and CSUM happens only on a valid/ready handshake.

Top module: `pkt_formatter`

## Requirements
- R1: After reset the block is idle: `out_valid`, `out_last`, `busy` and `reject` are all 0.
- R2: Register 0x0 is the type register. Bits 15:8 select the kind: 0x10 means short and 0x40 means long. Bits 5:0 hold the data type. The first byte sent is {2'b00, data type}. A trigger with any other kind is rejected.
- R3: A short packet is four bytes: the first byte, then the low byte of payload word 0 (address 0x4), then its high byte, then the ECC byte. `out_last` is set on the fourth byte. The word count register (0x2) has no effect on a short packet.
- R4: A long packet sends the following, in order:
  - the first byte;
  - the word count low byte, then the word count high byte;
  - the ECC byte;
  - the payload bytes, as many as the word count says;
  - the checksum low byte, then the checksum high byte.

  `out_last` is set only on the checksum high byte.
- R5: Payload bytes are taken two per word, lower-indexed byte in bits 7:0. Words 0 to 3 sit at addresses 0x4, 0x6, 0x8 and 0xA.
- R6: ECC bit i (i = 0..5) is the XOR of the 24-bit header {byte2, byte1, byte0} masked by the following value. ECC bits 7:6 are 0.

  | ECC bit | Mask     |
  |---------|----------|
  | 0       | 0xF12CB7 |
  | 1       | 0xF2555B |
  | 2       | 0x749A6D |
  | 3       | 0xB8E38E |
  | 4       | 0xDF03F0 |
  | 5       | 0xEFFC00 |
- R7: The checksum is computed over the payload bytes, each processed LSB first. It uses the reflected polynomial 0x8408, starts from 0xFFFF and has no final inversion. A zero-length long packet therefore sends 0xFFFF.
- R8: A long packet whose word count exceeds 8 is rejected with no output.
- R9: The transmit register is at address 0xC. Only a write with bit 0 = 1 triggers. A write of 0 does nothing. An accepted trigger raises `busy` and `out_valid` in the next cycle.
- R10: A trigger while `enable` is 0 is rejected: `reject` pulses for one cycle and nothing is sent.
- R11: `busy` stays high until the last byte is accepted and then falls in the next cycle. While `busy` is high, triggers are ignored without a reject and register writes have no effect.
- R12: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; triggers are refused when low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register byte address |
| wr_data | input | 16 | Register write data |
| out_data | output | 8 | Packet byte |
| out_valid | output | 1 | Byte on out_data is valid |
| out_last | output | 1 | Byte is the final byte of the packet |
| out_ready | input | 1 | Sink accepts the byte |
| busy | output | 1 | A packet is being sent |
| reject | output | 1 | One-cycle pulse: the last trigger was refused |

## Verification
The hardest situation to reach from the ports is a trigger or payload rewrite that lands while a packet is still in flight. The stream normally drains in a few cycles. The stimulus reaches it by holding `out_ready` low, which freezes the formatter mid-header. A new word and a second trigger are then written during the freeze. The bench confirms that the same packet comes out twice, unchanged, once the sink releases. Zero-length and over-length long packets, unknown kinds and disabled triggers are driven as directed cases. Random packets with random backpressure cover the ECC and checksum arithmetic.

// File: rtl/pkt_fmt_pkg.sv
package pkt_fmt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_PAY  = 2'd2,
        ST_CSUM = 2'd3
    } fmt_state_t;

    localparam logic [7:0]  KIND_SHORT = 8'h10;
    localparam logic [7:0]  KIND_LONG  = 8'h40;
    localparam int unsigned ADR_TYPE   = 0;
    localparam int unsigned ADR_WCNT   = 2;
    localparam int unsigned ADR_WBASE  = 4;
    localparam logic [15:0] CRC_SEED   = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_R = 16'h8408;

endpackage

// File: rtl/pkt_fmt_regs.sv
module pkt_fmt_regs #(
    parameter int ADDR_W = 4,
    parameter int NWORDS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lock,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [15:0]             wr_data,
    output logic [15:0]             type_q,
    output logic [15:0]             wcnt_q,
    output logic [NWORDS-1:0][15:0] words_q,
    output logic                    trig
);
    import pkt_fmt_pkg::*;

    localparam int unsigned ADR_TRIG = ADR_WBASE + 2 * NWORDS;

    logic [NWORDS-1:0] word_hit;

    // One address comparator per payload word, at consecutive even addresses
    for (genvar gi = 0; gi < NWORDS; gi++) begin : g_word_dec
        assign word_hit[gi] = wr_en && !lock &&
                              (wr_addr == ADDR_W'(ADR_WBASE + 2 * gi));
    end

    assign trig = wr_en && (wr_addr == ADDR_W'(ADR_TRIG)) && wr_data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            type_q  <= '0;
            wcnt_q  <= '0;
            words_q <= '0;
        end else begin
            if (wr_en && !lock && wr_addr == ADDR_W'(ADR_TYPE)) type_q <= wr_data;
            if (wr_en && !lock && wr_addr == ADDR_W'(ADR_WCNT)) wcnt_q <= wr_data;
            for (int i = 0; i < NWORDS; i++) begin
                if (word_hit[i]) words_q[i] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/pkt_fmt_ecc.sv
module pkt_fmt_ecc (
    input  logic [23:0] hdr,
    output logic [7:0]  ecc
);
    localparam logic [5:0][23:0] PMASK = {
        24'hEFFC00, 24'hDF03F0, 24'hB8E38E,
        24'h749A6D, 24'hF2555B, 24'hF12CB7
    };

    for (genvar gb = 0; gb < 6; gb++) begin : g_par
        assign ecc[gb] = ^(hdr & PMASK[gb]);
    end
    assign ecc[7:6] = 2'b00;

endmodule

// File: rtl/pkt_fmt_crc.sv
module pkt_fmt_crc (
    input  logic [15:0] crc_in,
    input  logic [7:0]  din,
    output logic [15:0] crc_out
);
    import pkt_fmt_pkg::*;

    always_comb begin
        logic [15:0] c;
        logic        fb;
        c = crc_in;
        for (int b = 0; b < 8; b++) begin
            fb = c[0] ^ din[b];
            c  = c >> 1;
            if (fb) c = c ^ CRC_POLY_R;
        end
        crc_out = c;
    end

endmodule

// File: rtl/pkt_formatter.sv
module pkt_formatter #(
    parameter int ADDR_W = 4,
    parameter int NWORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    output logic [7:0]        out_data,
    output logic              out_valid,
    output logic              out_last,
    input  logic              out_ready,
    output logic              busy,
    output logic              reject
);
    import pkt_fmt_pkg::*;

    localparam int MAX_BYTES = 2 * NWORDS;
    localparam int WI_W      = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam int IDX_W     = WI_W + 1;
    localparam int LEN_W     = IDX_W + 1;

    fmt_state_t              state_q, state_d;
    logic [IDX_W-1:0]        idx_q, idx_d;
    logic [15:0]             crc_q, crc_d, crc_upd;
    logic                    reject_q, reject_d;

    logic [15:0]             type_q, wcnt_q;
    logic [NWORDS-1:0][15:0] words_q;
    logic                    trig;

    logic                    is_long, kind_ok, len_ok, start_req, accept, fire;
    logic [7:0]              di_byte, hdr1, hdr2, ecc_byte, pay_byte;
    logic                    pay_last, hdr_end, csum_end;

    pkt_fmt_regs #(.ADDR_W(ADDR_W), .NWORDS(NWORDS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock    (busy),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .type_q  (type_q),
        .wcnt_q  (wcnt_q),
        .words_q (words_q),
        .trig    (trig)
    );

    // Header fields
    assign is_long  = (type_q[15:8] == KIND_LONG);
    assign kind_ok  = is_long || (type_q[15:8] == KIND_SHORT);
    assign len_ok   = !is_long || (wcnt_q <= 16'(MAX_BYTES));
    assign di_byte  = {2'b00, type_q[5:0]};
    assign hdr1     = is_long ? wcnt_q[7:0]  : words_q[0][7:0];
    assign hdr2     = is_long ? wcnt_q[15:8] : words_q[0][15:8];

    pkt_fmt_ecc u_ecc (
        .hdr (
            {hdr2, hdr1, di_byte}),
        .ecc (ecc_byte)
    );

    // Payload byte select: word from the upper index bits, half from bit 0
    assign pay_byte = idx_q[0] ? words_q[idx_q[IDX_W-1:1]][15:8]
                               : words_q[idx_q[IDX_W-1:1]][7:0];

    pkt_fmt_crc u_crc (
        .crc_in  (crc_q),
        .din     (pay_byte),
        .crc_out (crc_upd)
    );

    assign start_req = trig && !busy;
    assign accept    = start_req && enable && kind_ok && len_ok;
    assign fire      = out_valid && out_ready;
    assign hdr_end   = (idx_q == IDX_W'(3));
    assign csum_end  = (idx_q == IDX_W'(1));
    assign pay_last  = ((LEN_W'(idx_q) + LEN_W'(1)) == wcnt_q[LEN_W-1:0]);

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        idx_d    = idx_q;
        crc_d    = crc_q;
        reject_d = start_req && !accept;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_HDR;
                    idx_d   = '0;
                    crc_d   = CRC_SEED;
                end
            end
            ST_HDR: begin
                if (fire) begin
                    if (hdr_end) begin
                        idx_d = '0;
                        if (!is_long)
                            state_d = ST_IDLE;
                        else if (wcnt_q == 16'd0)
                            state_d = ST_CSUM;
                        else
                            state_d = ST_PAY;
                    end else begin
                        idx_d = idx_q + IDX_W'(1);
                    end
                end
            end
            ST_PAY: begin
                if (fire) begin
                    crc_d = crc_upd;
                    if (pay_last) begin
                        state_d = ST_CSUM;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + IDX_W'(1);
                    end
                end
            end
            ST_CSUM: begin
                if (fire) begin
                    if (csum_end) begin
                        state_d = ST_IDLE;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + IDX_W'(1);
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            idx_q    <= '0;
            crc_q    <= CRC_SEED;
            reject_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            idx_q    <= idx_d;
            crc_q    <= crc_d;
            reject_q <= reject_d;
        end
    end

    // Outputs
    always_comb begin
        out_valid = (state_q != ST_IDLE);
        busy      = (state_q != ST_IDLE);
        reject    = reject_q;
        out_data  = 8'h00;
        out_last  = 1'b0;
        unique case (state_q)
            ST_IDLE: out_data = 8'h00;
            ST_HDR: begin
                unique case (idx_q[1:0])
                    2'd0: out_data = di_byte;
                    2'd1: out_data = hdr1;
                    2'd2: out_data = hdr2;
                    2'd3: out_data = ecc_byte;
                    default: out_data = 8'h00;
                endcase
                out_last = hdr_end && !is_long;
            end
            ST_PAY:  out_data = pay_byte;
            ST_CSUM: begin
                out_data = idx_q[0] ? crc_q[15:8] : crc_q[7:0];
                out_last = csum_end;
            end
            default: out_data = 8'h00;
        endcase
    end

endmodule

// File: rtl/pkt_formatter_chk.sv
module pkt_formatter_chk #(
    parameter int ADDR_W = 4,
    parameter int NWORDS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [15:0]       wr_data,
    input logic [7:0]        out_data,
    input logic              out_valid,
    input logic              out_last,
    input logic              out_ready,
    input logic              busy,
    input logic              reject
);
    localparam int unsigned TRIG_ADR = 4 + 2 * NWORDS;

    logic trig_seen;
    assign trig_seen = wr_en && (wr_addr == ADDR_W'(TRIG_ADR)) && wr_data[0];

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !out_valid && !out_last);

    assert_last_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> !busy);

    assert_start_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(trig_seen && enable));

    assert_disabled_refused_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && trig_seen && !enable |=> reject && !busy);

    assert_busy_trigger_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy && trig_seen |=> !reject);

    assert_reject_no_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> !busy && !out_valid);

    assert_stall_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

endmodule

bind pkt_formatter pkt_formatter_chk #(.ADDR_W(ADDR_W), .NWORDS(NWORDS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_ready (out_ready),
    .busy      (busy),
    .reject    (reject)
);

// File: tb/tb_pkt_formatter.sv
module tb_pkt_formatter;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic        wr_en;
    logic [3:0]  wr_addr;
    logic [15:0] wr_data;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        out_last;
    logic        out_ready;
    logic        busy;
    logic        reject;

    always #2 clk = ~clk;

    pkt_formatter dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .out_data(out_data), .out_valid(out_valid), .out_last(out_last),
        .out_ready(out_ready), .busy(busy), .reject(reject)
    );

    int checks = 0;
    int errors = 0;

    logic [15:0] m_type, m_wc;
    logic [15:0] m_w [4];
    logic [7:0]  exp_b [16];
    int          exp_n;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [7:0] f_ecc(input logic [23:0] h);
        logic [23:0] m [6];
        logic [7:0]  e;
        m[0] = 24'hF12CB7; m[1] = 24'hF2555B; m[2] = 24'h749A6D;
        m[3] = 24'hB8E38E; m[4] = 24'hDF03F0; m[5] = 24'hEFFC00;
        e = 8'h00;
        for (int i = 0; i < 6; i++) e[i] = ^(h & m[i]);
        return e;
    endfunction

    function automatic logic [15:0] f_crc_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int b = 0; b < 8; b++) begin
            if ((r[0] ^ d[b]) == 1'b1) r = (r >> 1) ^ 16'h8408;
            else                       r = r >> 1;
        end
        return r;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 4'h0; wr_data = 16'h0;
    endtask

    task automatic program_regs(input logic [15:0] t, input logic [15:0] wc,
                                input logic [15:0] w0, input logic [15:0] w1,
                                input logic [15:0] w2, input logic [15:0] w3);
        wr(4'h0, t);  wr(4'h2, wc);
        wr(4'h4, w0); wr(4'h6, w1); wr(4'h8, w2); wr(4'hA, w3);
        m_type = t; m_wc = wc;
        m_w[0] = w0; m_w[1] = w1; m_w[2] = w2; m_w[3] = w3;
    endtask

    task automatic build_expected();
        logic        lng;
        logic [7:0]  b1, b2, pb;
        logic [15:0] crc;
        lng = (m_type[15:8] == 8'h40);
        exp_b[0] = {2'b00, m_type[5:0]};
        b1 = lng ? m_wc[7:0]  : m_w[0][7:0];
        b2 = lng ? m_wc[15:8] : m_w[0][15:8];
        exp_b[1] = b1; exp_b[2] = b2;
        exp_b[3] = f_ecc({b2, b1, exp_b[0]});
        exp_n = 4;
        if (lng) begin
            crc = 16'hFFFF;
            for (int k = 0; k < int'(m_wc); k++) begin
                pb = k[0] ? m_w[k/2][15:8] : m_w[k/2][7:0];
                exp_b[exp_n] = pb;
                exp_n++;
                crc = f_crc_byte(crc, pb);
            end
            exp_b[exp_n] = crc[7:0];  exp_n++;
            exp_b[exp_n] = crc[15:8]; exp_n++;
        end
    endtask

    // Entered at a negedge with a packet in flight; returns at a negedge
    task automatic collect(input string req, input int pct);
        logic [7:0] got_d [16];
        logic       got_l [16];
        int         got;
        int         guard;
        logic       held;
        logic [7:0] held_d;
        logic       held_l;
        got = 0; guard = 0; held = 1'b0; held_d = 8'h0; held_l = 1'b0;
        while (got < exp_n && guard < 400) begin
            out_ready = (($urandom % 100) < pct);
            #1;
            if (held) begin
                chk(out_valid && out_data == held_d && out_last == held_l,
                    "R12", "stall hold", out_data, held_d);
            end
            held = 1'b0;
            if (out_valid && out_ready) begin
                if (got < 16) begin
                    got_d[got] = out_data;
                    got_l[got] = out_last;
                end
                got++;
            end else if (out_valid) begin
                held = 1'b1; held_d = out_data; held_l = out_last;
            end
            @(negedge clk);
            guard++;
        end
        out_ready = 1'b0;
        chk(got == exp_n, req, "byte count", got, exp_n);
        for (int k = 0; k < exp_n && k < got; k++) begin
            chk(got_d[k] == exp_b[k], req, $sformatf("byte %0d", k), got_d[k], exp_b[k]);
            chk(got_l[k] == (k == exp_n - 1), req, $sformatf("last flag %0d", k),
                got_l[k], (k == exp_n - 1));
        end
        chk(!busy && !out_valid, "R11", "busy released after last", busy, 0);
    endtask

    task automatic expect_reject(input string req);
        chk(reject == 1'b1, req, "reject pulse", reject, 1);
        chk(!busy && !out_valid, req, "no output on reject", out_valid, 0);
        @(negedge clk);
        chk(!reject && !busy, req, "reject one cycle", reject, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);
        rst_n = 1'b0; enable = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        out_ready = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!out_valid && !out_last && !busy && !reject, "R1", "reset idle",
            {out_valid, out_last, busy, reject}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3, R6, R9: short packet, word count ignored
        program_regs(16'h1005, 16'h00FF, 16'h3412, 16'hAAAA, 16'hBBBB, 16'hCCCC);
        build_expected();
        wr(4'hC, 16'h0001);
        chk(busy && out_valid, "R9", "busy after trigger", busy, 1);
        collect("R3", 100);

        // R4, R5, R7: full eight-byte long packet with backpressure
        program_regs(16'h4039, 16'd8, 16'h2301, 16'h6745, 16'hAB89, 16'hEFCD);
        build_expected();
        wr(4'hC, 16'h0001);
        collect("R4", 50);

        // R7: zero-length long packet gives checksum FFFF
        program_regs(16'h4029, 16'd0, 16'h0, 16'h0, 16'h0, 16'h0);
        build_expected();
        chk(exp_b[4] == 8'hFF && exp_b[5] == 8'hFF, "R7", "seed checksum", exp_b[4], 8'hFF);
        wr(4'hC, 16'h0001);
        collect("R7", 100);

        // R8: over-length long packet refused
        program_regs(16'h4029, 16'd9, 16'h1, 16'h2, 16'h3, 16'h4);
        wr(4'hC, 16'h0001);
        expect_reject("R8");

        // R2: unknown kind refused
        program_regs(16'h2005, 16'd0, 16'h1, 16'h2, 16'h3, 16'h4);
        wr(4'hC, 16'h0001);
        expect_reject("R2");

        // R10: disabled block refuses
        program_regs(16'h1005, 16'd0, 16'h5566, 16'h0, 16'h0, 16'h0);
        enable = 1'b0;
        wr(4'hC, 16'h0001);
        expect_reject("R10");
        enable = 1'b1;

        // R9: writing 0 to the transmit register does nothing
        wr(4'hC, 16'h0000);
        chk(!busy && !reject && !out_valid, "R9", "zero write no start", busy, 0);

        // R11: trigger and payload write during a frozen packet are ignored
        program_regs(16'h4017, 16'd3, 16'hBEEF, 16'h00C3, 16'h0, 16'h0);
        build_expected();
        wr(4'hC, 16'h0001);
        wr(4'h4, 16'h1111);
        wr(4'hC, 16'h0001);
        chk(!reject && busy, "R11", "busy trigger ignored", reject, 0);
        collect("R11", 60);
        wr(4'hC, 16'h0001);
        collect("R11", 100);

        // Random packets
        for (int n = 0; n < 60; n++) begin
            logic        lng;
            logic [15:0] t, wc;
            lng = $urandom % 2;
            t   = {lng ? 8'h40 : 8'h10, 2'b00, 6'($urandom)};
            wc  = lng ? 16'($urandom % 9) : 16'($urandom);
            program_regs(t, wc, 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
            build_expected();
            wr(4'hC, 16'h0001);
            collect(lng ? "R4" : "R3", 70);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule